// File: doc/BRIEF.md
# Serial Boot Image Loader

This block loads a program image into an instruction memory from a stream of bytes. The bytes come from a serial receiver that has already deserialized them. Each byte arrives with a one-cycle valid strobe. A strap input is sampled during reset and selects one of two start-up modes.

With the strap low, the processor is released at once and runs whatever the memory already holds. With the strap high, the block waits for a frame and keeps the processor's run control low, so the processor stays parked at address zero. A frame is a marker byte, then a byte giving the number of words, then four bytes per word with the least significant byte first.

Each completed word is written to the next memory location, starting at word index zero. After the last write, a done flag rises and the processor is released. A wrong marker byte raises an error flag instead. The block then stays in that state until the next reset.

Top module: `prog_loader`

## Requirements
- R1: If `boot_strap` is low at the last reset edge, then from the first cycle after reset `core_run` is 1, `load_done` and `load_error` are 0, and no byte ever causes a memory write.
- R2: If `boot_strap` is high at the last reset edge, then after reset `core_run`, `load_done` and `load_error` are all 0, and they stay 0 while words are being written.
- R3: In boot mode, the first accepted byte must equal 0x55. Any other value sets `load_error` in the cycle after that byte is accepted. After that, `core_run` stays 0 and no later byte causes a memory write.
- R4: The byte accepted after the marker is an unsigned word count N (0 to 255). Exactly N memory writes follow it.
- R5: Each word is built from four accepted bytes. The first byte becomes bits [7:0] and the fourth becomes bits [31:24]; for example, B7, 00, 00, 10 gives 0x100000B7.
- R6: The words are written to `mem_addr` 0, 1, 2 and so on, in the order they arrive.
- R7: `mem_we` is high for exactly one cycle, namely the cycle right after the fourth byte of a word is accepted. `mem_wdata` and `mem_addr` are valid in that same cycle.
- R8: After the write pulse of word N-1, `load_done` and `core_run` both rise in the next cycle.
- R9: A count of zero sets `load_done` and `core_run` in the cycle after the count byte is accepted, with no memory write.
- R10: `load_done` and `load_error` stay set until reset and are never 1 together. Bytes that arrive after completion cause no write.
- R11: A byte is taken only in a cycle where `rx_valid` is 1. While `rx_valid` is 0, the value on `rx_byte` has no effect, and bytes may arrive back to back or with gaps between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_strap | input | 1 | Mode strap, sampled while reset is held |
| rx_valid | input | 1 | Byte strobe from the serial receiver |
| rx_byte | input | 8 | Received byte |
| mem_we | output | 1 | Instruction memory write strobe |
| mem_addr | output | ADDR_W | Word index being written |
| mem_wdata | output | 32 | Assembled word |
| load_done | output | 1 | Load complete (sticky) |
| load_error | output | 1 | Frame marker error (sticky) |
| core_run | output | 1 | Processor release; low keeps it at address zero |

## Verification
The checker tests these properties on every cycle:
- done and error are never set together, and each stays set once raised;
- every write strobe lasts exactly one cycle;
- the processor is never released during a write or after an error;
- no write occurs once loading has finished.

Other behaviour can only be shown by the bench scenarios, which model the expected writes:
- the little-endian packing of words;
- consecutive addresses starting from zero;
- the exact cycle of each write and of the done flag;
- the zero-count case;
- the effect of the strap on start-up;
- ignoring bytes after an error or after completion, and ignoring `rx_byte` while `rx_valid` is low.

// File: rtl/loader_pkg.sv
// Shared types for the boot image loader.
package loader_pkg;
    // Frame parser states.
    typedef enum logic [2:0] {
        LD_SYNC,
        LD_COUNT,
        LD_DATA,
        LD_DONE,
        LD_FAIL,
        LD_DIRECT
    } ld_state_t;
endpackage

// File: rtl/loader_frame_fsm.sv
// Frame parser: checks the marker, captures the word count and tracks completion.
// Assumes last_word pulses with the write strobe of the final word.
module loader_frame_fsm
    import loader_pkg::*;
#(
    parameter logic [7:0] SYNC_VALUE = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       boot_strap,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       last_word,
    output ld_state_t  state_o,
    output logic [7:0] count_o
);
    ld_state_t  state_q;
    logic [7:0] count_q;

    // State register; the strap picks the start state while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= boot_strap ? LD_SYNC : LD_DIRECT;
            count_q <= '0;
        end else begin
            case (state_q)
                LD_SYNC:
                    if (rx_valid)
                        state_q <= (rx_byte == SYNC_VALUE) ? LD_COUNT : LD_FAIL;
                LD_COUNT:
                    if (rx_valid) begin
                        count_q <= rx_byte;
                        state_q <= (rx_byte == 8'd0) ? LD_DONE : LD_DATA;
                    end
                LD_DATA:
                    if (last_word)
                        state_q <= LD_DONE;
                default:
                    state_q <= state_q;
            endcase
        end
    end

    assign state_o = state_q;
    assign count_o = count_q;
endmodule

// File: rtl/loader_word_pack.sv
// Word assembler: shifts bytes in, least significant first, and pulses word_rdy
// for one cycle once the last byte of a word is in place.
// Assumes WORD_W is a multiple of 8.
module loader_word_pack #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [7:0]        byte_in,
    output logic              word_rdy,
    output logic [WORD_W-1:0] word
);
    localparam int NBYTES = WORD_W / 8;
    localparam int LANE_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NBYTES - 1);

    logic [LANE_W-1:0] lane_q;
    logic [WORD_W-1:0] shreg_q;
    logic              rdy_q;

    // Shift register, lane counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q  <= '0;
            shreg_q <= '0;
            rdy_q   <= 1'b0;
        end else begin
            rdy_q <= take && (lane_q == LAST_LANE);
            if (take) begin
                shreg_q <= {byte_in, shreg_q[WORD_W-1:8]};
                lane_q  <= (lane_q == LAST_LANE) ? '0 : lane_q + 1'b1;
            end
        end
    end

    assign word_rdy = rdy_q;
    assign word     = shreg_q;
endmodule

// File: rtl/loader_wr_port.sv
// Memory write port: turns each completed word into a one-cycle write at the
// next word index and flags the final word.
// Assumes ADDR_W >= 8, so a count of 255 fits.
module loader_wr_port #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_rdy,
    input  logic [WORD_W-1:0] word,
    input  logic [7:0]        count,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              last_word
);
    logic [ADDR_W-1:0] widx_q;
    logic [ADDR_W-1:0] last_idx;

    // Word index, advanced by each write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            widx_q <= '0;
        else if (word_rdy)
            widx_q <= widx_q + 1'b1;
    end

    // Index of the final word of the frame.
    always_comb begin
        last_idx = ADDR_W'(count - 8'd1);
    end

    assign mem_we    = word_rdy;
    assign mem_addr  = widx_q;
    assign mem_wdata = word;
    assign last_word = word_rdy && (widx_q == last_idx);
endmodule

// File: rtl/prog_loader.sv
// Boot image loader top: parses the marker/count/word stream, writes the words
// to instruction memory and releases the processor when loading completes.
// Assumes rx_valid is a one-cycle strobe per byte from an external receiver.
module prog_loader
    import loader_pkg::*;
#(
    parameter int         ADDR_W     = 8,
    parameter logic [7:0] SYNC_VALUE = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_strap,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic              load_done,
    output logic              load_error,
    output logic              core_run
);
    localparam int WORD_W = 32;

    ld_state_t         state;
    logic [7:0]        count;
    logic              last_word;
    logic              take;
    logic              word_rdy;
    logic [WORD_W-1:0] word;

    loader_frame_fsm #(.SYNC_VALUE(SYNC_VALUE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_strap(boot_strap),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .last_word (last_word),
        .state_o   (state),
        .count_o   (count)
    );

    // Payload bytes are taken only while the frame is in its data phase.
    assign take = rx_valid && (state == LD_DATA);

    loader_word_pack #(.WORD_W(WORD_W)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .byte_in (rx_byte),
        .word_rdy(word_rdy),
        .word    (word)
    );

    loader_wr_port #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_rdy (word_rdy),
        .word     (word),
        .count    (count),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .last_word(last_word)
    );

    assign load_done  = (state == LD_DONE);
    assign load_error = (state == LD_FAIL);
    assign core_run   = (state == LD_DONE) || (state == LD_DIRECT);
endmodule

// File: rtl/prog_loader_chk.sv
// Protocol checker for prog_loader, attached with bind below.
module prog_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_we,
    input logic load_done,
    input logic load_error,
    input logic core_run
);
    // R10: done and error are mutually exclusive.
    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_done && load_error));

    // R10: done stays set.
    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done);

    // R3: error stays set and keeps the processor held.
    assert_error_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_error |=> (load_error && !core_run));

    // R7: a write strobe lasts a single cycle.
    assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R2: the processor is held while a word is written.
    assert_hold_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !core_run);

    // R8: completion releases the processor and ends all writes.
    assert_done_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> (core_run && !mem_we));
endmodule

bind prog_loader prog_loader_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_we    (mem_we),
    .load_done (load_done),
    .load_error(load_error),
    .core_run  (core_run)
);

// File: tb/sim_prog_loader.sv
`timescale 1ns/1ps
module sim_prog_loader;
    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] at;
    } wr_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_strap = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        mem_we;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic        load_done;
    logic        load_error;
    logic        core_run;

    int          total = 0;
    int          bad = 0;
    logic [31:0] cyc = '0;
    logic [7:0]  exp_addr = '0;
    logic [31:0] acc_cyc;
    wr_item_t    exp_q[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    prog_loader u0 (
        .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .load_done(load_done), .load_error(load_error), .core_run(core_run)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: each write strobe must match the oldest expected write.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R4/R10 unexpected write actual=%h expected=none", mem_wdata);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                chk("R6 address", {24'd0, mem_addr}, {24'd0, it.addr});
                chk("R5 data", mem_wdata, it.data);
                chk("R7 write cycle", cyc, it.at);
            end
        end
    end

    task automatic do_reset(input logic strap);
        rst_n = 1'b0;
        boot_strap = strap;
        rx_valid = 1'b0;
        exp_addr = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        boot_strap = ~strap;
        @(negedge clk);
    endtask

    task automatic align();
        @(posedge clk);
        #1;
    endtask

    // Drive one byte for one cycle; gap idle cycles follow, with junk on rx_byte.
    task automatic send_byte(input logic [7:0] b, input int gap);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(posedge clk);
        #1 acc_cyc = cyc;
        rx_valid = 1'b0;
        rx_byte  = 8'hAA;
        repeat (gap) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Driver: send a word LSB first and queue the expected write.
    task automatic send_word(input logic [31:0] w, input int gap, input logic expect_wr);
        for (int i = 0; i < 4; i++) send_byte(w[8*i +: 8], (i == 3) ? 0 : gap);
        if (expect_wr) begin
            exp_q.push_back('{addr: exp_addr, data: w, at: acc_cyc});
            exp_addr = exp_addr + 1;
        end
    endtask

    initial begin
        #800000;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: direct start, bytes are ignored.
        do_reset(1'b0);
        chk("R1 core_run", {31'd0, core_run}, 32'd1);
        chk("R1 done", {31'd0, load_done}, 32'd0);
        chk("R1 error", {31'd0, load_error}, 32'd0);
        align();
        send_byte(8'h55, 0);
        send_byte(8'h01, 0);
        send_word(32'h12345678, 0, 1'b0);
        @(negedge clk);
        chk("R1 still running", {31'd0, core_run}, 32'd1);
        chk("R1 no done", {31'd0, load_done}, 32'd0);

        // R2, R4, R5, R6, R7, R8, R11: a three-word load.
        do_reset(1'b1);
        chk("R2 held", {31'd0, core_run}, 32'd0);
        chk("R2 done low", {31'd0, load_done}, 32'd0);
        chk("R2 error low", {31'd0, load_error}, 32'd0);
        align();
        rx_byte = 8'h33;
        repeat (4) align();
        chk("R11 junk while invalid", {31'd0, load_error}, 32'd0);
        send_byte(8'h55, 2);
        send_byte(8'h03, 1);
        send_word(32'h100000B7, 2, 1'b1);
        send_word(32'hDEADBEEF, 0, 1'b1);
        chk("R2 held mid-load", {31'd0, core_run}, 32'd0);
        send_word(32'h00000013, 1, 1'b1);
        @(negedge clk);
        chk("R8 done not before write", {31'd0, load_done}, 32'd0);
        @(negedge clk);
        chk("R8 done", {31'd0, load_done}, 32'd1);
        chk("R8 released", {31'd0, core_run}, 32'd1);
        align();
        send_word(32'hCAFEF00D, 0, 1'b0);
        @(negedge clk);
        chk("R10 done sticky", {31'd0, load_done}, 32'd1);
        chk("R6 all writes seen", exp_q.size(), 32'd0);

        // R3, R10: bad marker.
        do_reset(1'b1);
        align();
        send_byte(8'hAA, 0);
        @(negedge clk);
        chk("R3 error", {31'd0, load_error}, 32'd1);
        chk("R3 held", {31'd0, core_run}, 32'd0);
        align();
        send_byte(8'h55, 0);
        send_byte(8'h01, 0);
        send_word(32'h0BADF00D, 0, 1'b0);
        @(negedge clk);
        chk("R3 error sticky", {31'd0, load_error}, 32'd1);
        chk("R10 no done with error", {31'd0, load_done}, 32'd0);
        chk("R3 still held", {31'd0, core_run}, 32'd0);

        // R9: zero count.
        do_reset(1'b1);
        align();
        send_byte(8'h55, 0);
        send_byte(8'h00, 0);
        @(negedge clk);
        chk("R9 done", {31'd0, load_done}, 32'd1);
        chk("R9 released", {31'd0, core_run}, 32'd1);
        align();
        send_word(32'h11223344, 0, 1'b0);
        @(negedge clk);
        chk("R9 no write queue", exp_q.size(), 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule